// File: doc/BRIEF.md
# Regex Start-Character Candidate Finder

This block sits at the front of a pattern-search pipeline. It takes an in-order byte stream, sixteen bytes per beat, and tests every byte against the first step of a compiled pattern. Each byte that passes becomes a candidate. For every candidate the block builds a task holding the byte's absolute offset in the stream and the number of the text line it sits on. A downstream matching unit uses these two values to replay the stream from that point and decide whether the full pattern matches.

The tasks from one beat go to a bank of parallel matching units, one task per unit per beat. Lane i goes to unit (i + k) mod UNITS. The rotation k comes from a free-running LFSR, so files with a regular layout do not keep loading the same unit. Each unit has a small task queue. When any queue is full, the input stalls through its ready signal and no task is lost.

Top module: `rcf_candidate_finder`

## Requirements
- R1: While reset is held and on the first cycle after it, no unit sees a valid task and in_ready is 1. The stream offset restarts at 0 and the line count restarts at 1.
- R2: Match mode 0 (pair) accepts a byte equal to spec_lo or to spec_hi.
- R3: Match mode 1 (not-pair) accepts a byte that differs from both spec_lo and spec_hi.
- R4: Match mode 2 (range) accepts a byte c with spec_lo <= c <= spec_hi, compared as unsigned values.
- R5: Match mode 3 (not-range) accepts a byte outside the span [spec_lo, spec_hi].
- R6: A task's offset is the number of bytes accepted before that byte. Lane 0 (in_data[7:0]) is the earliest byte of a beat. Each accepted beat advances the offset by 16.
- R7: A task's line is 1 plus the number of 0x0A bytes that come before it in the stream. A 0x0A byte therefore belongs to the line it ends.
- R8: Every accepted candidate reaches exactly one unit exactly once, and no other task is produced.
- R9: The tasks a given unit receives come in strictly increasing offset order.
- R10: A task is held stable at a unit until that unit's task_ready is seen. When any unit queue is full, in_ready is 0 and no beat is taken.
- R11: The lane-to-unit rotation changes from cycle to cycle. A stream whose only candidate is always in lane 0 is spread over several units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat on in_data is valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | LANES*8 | Beat bytes, lane 0 in bits 7:0 |
| spec_op | input | 2 | Start test: 0 pair, 1 not-pair, 2 range, 3 not-range |
| spec_lo | input | 8 | First character or lower bound |
| spec_hi | input | 8 | Second character or upper bound |
| task_valid | output | UNITS | Unit u has a task waiting |
| task_ready | input | UNITS | Unit u takes its task this cycle |
| task_pos | output | UNITS*POS_W | Offset of each unit's task |
| task_line | output | UNITS*LINE_W | Line number of each unit's task |

## Verification
A corrupted offset or line counter shows up at the ports on the first task that follows the bad beat. Because both counters accumulate, every later task stays wrong too, so any candidate after the fault shows it. A queue pointer that slips shows up at a unit as a repeated or skipped task, or as an offset lower than the one before it, on the very next pop. A stuck rotation takes longer to see. It shows only over a run of beats, as candidates from a single lane landing on a single unit.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

   typedef enum logic [1:0] {
      MATCH_PAIR      = 2'd0,
      MATCH_NOT_PAIR  = 2'd1,
      MATCH_RANGE     = 2'd2,
      MATCH_NOT_RANGE = 2'd3
   } match_op_e;

   localparam logic [7:0] LINE_END = 8'h0A;

   function automatic logic char_accept(match_op_e op, logic [7:0] lo,
                                        logic [7:0] hi, logic [7:0] c);
      logic eq_any;
      logic in_span;
      eq_any  = (c == lo) || (c == hi);
      in_span = (c >= lo) && (c <= hi);
      case (op)
         MATCH_PAIR:      return eq_any;
         MATCH_NOT_PAIR:  return !eq_any;
         MATCH_RANGE:     return in_span;
         default:         return !in_span;
      endcase
   endfunction

endpackage

// File: rtl/rcf_lane_scan.sv
module rcf_lane_scan
   import rcf_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int POS_W  = 32,
   parameter int LINE_W = 32,
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic [LANES*8-1:0]      beat,
   input  match_op_e               op,
   input  logic [7:0]              lo,
   input  logic [7:0]              hi,
   input  logic [POS_W-1:0]        base_pos,
   input  logic [LINE_W-1:0]       base_line,
   output logic [LANES-1:0]        lane_hit,
   output logic [LANES*POS_W-1:0]  lane_pos,
   output logic [LANES*LINE_W-1:0] lane_line,
   output logic [CNT_W-1:0]        nl_total
);

   logic [LANES-1:0] is_nl;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_hit[i] = char_accept(op, lo, hi, beat[i*8 +: 8]);
      assign is_nl[i]    = (beat[i*8 +: 8] == LINE_END);
      assign lane_pos[i*POS_W +: POS_W] = base_pos + POS_W'(i);
   end

   always_comb begin
      logic [CNT_W-1:0] run;
      run = '0;
      lane_line = '0;
      for (int i = 0; i < LANES; i++) begin
         lane_line[i*LINE_W +: LINE_W] = base_line + LINE_W'(run);
         run = run + CNT_W'(is_nl[i]);
      end
      nl_total = run;
   end

endmodule

// File: rtl/rcf_shuffle.sv
module rcf_shuffle #(
   parameter int               LANES     = 16,
   parameter int               UNITS     = 16,
   parameter int               POS_W     = 32,
   parameter int               LINE_W    = 32,
   parameter bit               SHUFFLE   = 1'b1,
   parameter int               LFSR_W    = 8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
   localparam int ROT_W = $clog2(UNITS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        lane_hit,
   input  logic [LANES*POS_W-1:0]  lane_pos,
   input  logic [LANES*LINE_W-1:0] lane_line,
   output logic [UNITS-1:0]        unit_push,
   output logic [UNITS*POS_W-1:0]  unit_pos,
   output logic [UNITS*LINE_W-1:0] unit_line,
   output logic [LFSR_W-1:0]       rot_state
);

   logic [ROT_W-1:0] offset;

   if (SHUFFLE) begin : g_lfsr
      logic [LFSR_W-1:0] lfsr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lfsr_q <= LFSR_SEED;
         else        lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
      end
      assign rot_state = lfsr_q;
      assign offset    = lfsr_q[ROT_W-1:0];
   end else begin : g_fixed
      assign rot_state = '0;
      assign offset    = '0;
   end

   always_comb begin
      unit_push = '0;
      unit_pos  = '0;
      unit_line = '0;
      for (int u = 0; u < UNITS; u++) begin
         logic [ROT_W-1:0] src;
         int               li;
         src = ROT_W'(u) - offset;
         li  = int'(src);
         if (li < LANES) begin
            unit_push[u] = lane_hit[li];
            unit_pos[u*POS_W +: POS_W]    = lane_pos[li*POS_W +: POS_W];
            unit_line[u*LINE_W +: LINE_W] = lane_line[li*LINE_W +: LINE_W];
         end
      end
   end

endmodule

// File: rtl/rcf_task_fifo.sv
module rcf_task_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] dout
);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;

   assign valid = (wptr != rptr);
   assign full  = ((wptr ^ rptr) == {1'b1, {AW{1'b0}}});
   assign dout  = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push && !full) wptr <= wptr + 1'b1;
         if (ready && valid) rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) mem[wptr[AW-1:0]] <= din;
   end

endmodule

// File: rtl/rcf_candidate_finder.sv
module rcf_candidate_finder
   import rcf_pkg::*;
#(
   parameter int               LANES     = 16,
   parameter int               UNITS     = 16,
   parameter int               POS_W     = 32,
   parameter int               LINE_W    = 32,
   parameter int               QDEPTH    = 4,
   parameter bit               SHUFFLE   = 1'b1,
   parameter int               LFSR_W    = 8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES*8-1:0]      in_data,
   input  logic [1:0]              spec_op,
   input  logic [7:0]              spec_lo,
   input  logic [7:0]              spec_hi,
   output logic [UNITS-1:0]        task_valid,
   input  logic [UNITS-1:0]        task_ready,
   output logic [UNITS*POS_W-1:0]  task_pos,
   output logic [UNITS*LINE_W-1:0] task_line
);

   localparam int CNT_W  = $clog2(LANES + 1);
   localparam int TASK_W = POS_W + LINE_W;

   if (UNITS < LANES)                  begin : g_chk_units $error("UNITS must be >= LANES"); end
   if ((UNITS & (UNITS - 1)) != 0)     begin : g_chk_pow2  $error("UNITS must be a power of two"); end
   if (UNITS < 2)                      begin : g_chk_min   $error("UNITS must be at least 2"); end
   if ((QDEPTH & (QDEPTH - 1)) != 0 || QDEPTH < 2)
                                       begin : g_chk_depth $error("QDEPTH must be a power of two >= 2"); end
   if (SHUFFLE && LFSR_W < $clog2(UNITS))
                                       begin : g_chk_lfsr  $error("LFSR_W too small for rotation"); end
   if (LFSR_SEED == '0)                begin : g_chk_seed  $error("LFSR_SEED must be nonzero"); end

   logic [POS_W-1:0]        base_pos;
   logic [LINE_W-1:0]       base_line;
   logic                    accept;
   logic [LANES-1:0]        lane_hit;
   logic [LANES*POS_W-1:0]  lane_pos;
   logic [LANES*LINE_W-1:0] lane_line;
   logic [CNT_W-1:0]        nl_total;
   logic [UNITS-1:0]        unit_push;
   logic [UNITS*POS_W-1:0]  unit_pos;
   logic [UNITS*LINE_W-1:0] unit_line;
   logic [LFSR_W-1:0]       rot_state;
   logic [UNITS-1:0]        q_full;

   assign in_ready = ~|q_full;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_pos  <= '0;
         base_line <= LINE_W'(1);
      end else if (accept) begin
         base_pos  <= base_pos + POS_W'(LANES);
         base_line <= base_line + LINE_W'(nl_total);
      end
   end

   rcf_lane_scan #(
      .LANES(LANES), .POS_W(POS_W), .LINE_W(LINE_W)
   ) i_scan (
      .beat(in_data), .op(match_op_e'(spec_op)), .lo(spec_lo), .hi(spec_hi),
      .base_pos(base_pos), .base_line(base_line),
      .lane_hit(lane_hit), .lane_pos(lane_pos), .lane_line(lane_line),
      .nl_total(nl_total)
   );

   rcf_shuffle #(
      .LANES(LANES), .UNITS(UNITS), .POS_W(POS_W), .LINE_W(LINE_W),
      .SHUFFLE(SHUFFLE), .LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED),
      .LFSR_TAPS(LFSR_TAPS)
   ) i_shuffle (
      .clk(clk), .rst_n(rst_n),
      .lane_hit(lane_hit), .lane_pos(lane_pos), .lane_line(lane_line),
      .unit_push(unit_push), .unit_pos(unit_pos), .unit_line(unit_line),
      .rot_state(rot_state)
   );

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      logic [TASK_W-1:0] q_out;
      rcf_task_fifo #(
         .DEPTH(QDEPTH), .W(TASK_W)
      ) i_q (
         .clk(clk), .rst_n(rst_n),
         .push(accept && unit_push[u]),
         .din({unit_line[u*LINE_W +: LINE_W], unit_pos[u*POS_W +: POS_W]}),
         .full(q_full[u]),
         .ready(task_ready[u]),
         .valid(task_valid[u]),
         .dout(q_out)
      );
      assign task_pos[u*POS_W +: POS_W]    = q_out[POS_W-1:0];
      assign task_line[u*LINE_W +: LINE_W] = q_out[TASK_W-1:POS_W];
   end

endmodule

// File: rtl/rcf_candidate_finder_chk.sv
module rcf_candidate_finder_chk #(
   parameter int LANES   = 16,
   parameter int UNITS   = 16,
   parameter int POS_W   = 32,
   parameter int LINE_W  = 32,
   parameter int LFSR_W  = 8,
   parameter bit SHUFFLE = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [UNITS-1:0]        task_valid,
   input logic [UNITS-1:0]        task_ready,
   input logic [UNITS*POS_W-1:0]  task_pos,
   input logic [UNITS*LINE_W-1:0] task_line,
   input logic [POS_W-1:0]        base_pos,
   input logic [LINE_W-1:0]       base_line,
   input logic [LFSR_W-1:0]       rot_state
);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (task_valid == '0 && in_ready && base_pos == '0);
      end
   end

   // R6
   disp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (base_pos == $past(base_pos) + POS_W'(LANES)));

   // R6
   disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) |=> $stable(base_pos));

   // R7
   line_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (base_line >= $past(base_line)));

   for (genvar u = 0; u < UNITS; u++) begin : g_unit_chk
      // R10
      task_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (task_valid[u] && !task_ready[u]) |=>
            (task_valid[u] && $stable(task_pos[u*POS_W +: POS_W])
                           && $stable(task_line[u*LINE_W +: LINE_W])));

      // R9
      unit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(task_valid[u] && task_ready[u]) && task_valid[u]) |->
            (task_pos[u*POS_W +: POS_W] > $past(task_pos[u*POS_W +: POS_W])));
   end

   if (SHUFFLE) begin : g_rot_chk
      // R11
      rot_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rot_state != '0);
   end

endmodule

bind rcf_candidate_finder rcf_candidate_finder_chk #(
   .LANES(LANES), .UNITS(UNITS), .POS_W(POS_W), .LINE_W(LINE_W),
   .LFSR_W(LFSR_W), .SHUFFLE(SHUFFLE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .task_valid(task_valid), .task_ready(task_ready),
   .task_pos(task_pos), .task_line(task_line),
   .base_pos(base_pos), .base_line(base_line), .rot_state(rot_state)
);

// File: tb/test_rcf_candidate_finder.sv
`timescale 1ns/1ps
module test_rcf_candidate_finder;

   localparam int LANES  = 16;
   localparam int UNITS  = 16;
   localparam int POS_W  = 32;
   localparam int LINE_W = 32;
   localparam int QDEPTH = 4;
   localparam int MAXB   = 40000;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_ready;
   logic [LANES*8-1:0]      in_data = '0;
   logic [1:0]              spec_op = 2'd0;
   logic [7:0]              spec_lo = 8'h00;
   logic [7:0]              spec_hi = 8'h00;
   logic [UNITS-1:0]        task_valid;
   logic [UNITS-1:0]        task_ready = '0;
   logic [UNITS*POS_W-1:0]  task_pos;
   logic [UNITS*LINE_W-1:0] task_line;

   rcf_candidate_finder #(
      .LANES(LANES), .UNITS(UNITS), .POS_W(POS_W), .LINE_W(LINE_W), .QDEPTH(QDEPTH)
   ) i_rcf_candidate_finder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .spec_op(spec_op), .spec_lo(spec_lo), .spec_hi(spec_hi),
      .task_valid(task_valid), .task_ready(task_ready),
      .task_pos(task_pos), .task_line(task_line)
   );

   always #2 clk = ~clk;

   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;
   int    cyc = 0;
   bit    exp_hit [MAXB];
   int    exp_line [MAXB];
   bit    got [MAXB];
   int    exp_cnt = 0;
   int    got_cnt = 0;
   int    b_pos = 0;
   int    b_line = 1;
   int    last_pos [UNITS];
   int    ready_pct = 100;
   string tag = "R2";
   bit [UNITS-1:0] seen_units = '0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: R8 run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic bit ref_accept(int op, int lo, int hi, int c);
      case (op)
         0: return (c == lo) || (c == hi);
         1: return (c != lo) && (c != hi);
         2: return (c >= lo) && (c <= hi);
         default: return !((c >= lo) && (c <= hi));
      endcase
   endfunction

   function automatic logic [7:0] rand_byte();
      int r;
      r = $urandom_range(9);
      case (r)
         0, 1, 2: return 8'h61;
         3:       return 8'h62;
         4:       return 8'h0A;
         5:       return 8'h41;
         6:       return 8'h63;
         default: return 8'($urandom_range(32, 126));
      endcase
   endfunction

   task automatic service();
      int p;
      int l;
      for (int u = 0; u < UNITS; u++)
         task_ready[u] = ($urandom_range(99) < ready_pct);
      for (int u = 0; u < UNITS; u++) begin
         if (task_valid[u] && task_ready[u]) begin
            p = int'(task_pos[u*POS_W +: POS_W]);
            l = int'(task_line[u*LINE_W +: LINE_W]);
            checks++;
            if (p < 0 || p >= MAXB || !exp_hit[p] || got[p]) begin
               errors++;
               $display("FAIL %s/R6/R8: unit %0d task offset %0d, actual=unexpected expected=new candidate", tag, u, p);
            end else begin
               got[p] = 1'b1;
               got_cnt++;
               checks++;
               if (l != exp_line[p]) begin
                  errors++;
                  $display("FAIL R7: offset %0d line actual=%0d expected=%0d", p, l, exp_line[p]);
               end
            end
            checks++;
            if (p <= last_pos[u]) begin
               errors++;
               $display("FAIL R9: unit %0d order actual=%0d expected>%0d", u, p, last_pos[u]);
            end
            last_pos[u] = p;
            seen_units[u] = 1'b1;
         end
      end
   endtask

   task automatic model(input logic [LANES*8-1:0] d);
      int nl;
      int c;
      nl = 0;
      for (int i = 0; i < LANES; i++) begin
         c = int'(d[i*8 +: 8]);
         if (ref_accept(int'(spec_op), int'(spec_lo), int'(spec_hi), c)) begin
            exp_hit[b_pos + i]  = 1'b1;
            exp_line[b_pos + i] = b_line + nl;
            exp_cnt++;
         end
         if (c == 10) nl++;
      end
      b_pos  += LANES;
      b_line += nl;
   endtask

   task automatic offer(input logic [LANES*8-1:0] d);
      do begin
         @(negedge clk);
         service();
         in_valid = 1'b1;
         in_data  = d;
      end while (!in_ready);
      model(d);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         service();
         in_valid = 1'b0;
      end
   endtask

   task automatic count_check(input string t);
      checks++;
      if (got_cnt != exp_cnt) begin
         errors++;
         $display("FAIL %s/R8: delivered actual=%0d expected=%0d", t, got_cnt, exp_cnt);
      end
   endtask

   task automatic run_mode(input int op, input int lo, input int hi, input string t, input int beats);
      logic [LANES*8-1:0] d;
      idle(1);
      spec_op = 2'(op);
      spec_lo = 8'(lo);
      spec_hi = 8'(hi);
      tag = t;
      ready_pct = 70;
      for (int b = 0; b < beats; b++) begin
         for (int i = 0; i < LANES; i++) d[i*8 +: 8] = rand_byte();
         offer(d);
         if ($urandom_range(7) == 0) idle(1);
      end
      ready_pct = 100;
      idle(QDEPTH + 8);
      count_check(t);
   endtask

   initial begin
      logic [LANES*8-1:0] all_a;
      logic [LANES*8-1:0] lead_a;
      void'($urandom(32'd1234));
      for (int u = 0; u < UNITS; u++) last_pos[u] = -1;
      for (int i = 0; i < LANES; i++) begin
         all_a[i*8 +: 8]  = 8'h61;
         lead_a[i*8 +: 8] = (i == 0) ? 8'h61 : 8'h7A;
      end

      repeat (3) @(negedge clk);
      checks++;
      if (task_valid != '0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: in reset valid=%h ready=%b expected valid=0 ready=1", task_valid, in_ready);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (task_valid != '0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: after reset valid=%h ready=%b expected valid=0 ready=1", task_valid, in_ready);
      end

      // directed: first beat sets offset origin 0 and line origin 1 (R1, R6, R7)
      spec_op = 2'd0; spec_lo = 8'h0A; spec_hi = 8'h78; tag = "R7";
      begin
         logic [LANES*8-1:0] d0;
         for (int i = 0; i < LANES; i++) d0[i*8 +: 8] = 8'h2E;
         d0[0*8 +: 8] = 8'h78;
         d0[3*8 +: 8] = 8'h0A;
         d0[4*8 +: 8] = 8'h0A;
         d0[9*8 +: 8] = 8'h78;
         offer(d0);
         offer(d0);
      end
      idle(QDEPTH + 8);
      count_check("R1");
      checks++;
      if (!got[0] || exp_line[0] != 1 || !got[4] || exp_line[4] != 2 || exp_line[9] != 3 || exp_line[16] != 3) begin
         errors++;
         $display("FAIL R7: directed line origins actual=%0d/%0d/%0d expected=1/2/3", exp_line[0], exp_line[4], exp_line[9]);
      end

      run_mode(0, 8'h61, 8'h62, "R2", 300);
      run_mode(1, 8'h61, 8'h0A, "R3", 300);
      run_mode(2, 8'h61, 8'h63, "R4", 300);
      run_mode(3, 8'h61, 8'h7A, "R5", 300);
      run_mode(0, 8'h0A, 8'h0A, "R7", 300);

      // back-pressure (R10)
      idle(1);
      spec_op = 2'd0; spec_lo = 8'h61; spec_hi = 8'h61; tag = "R10";
      ready_pct = 0;
      for (int b = 0; b < QDEPTH; b++) offer(all_a);
      idle(1);
      checks++;
      if (in_ready !== 1'b0 || task_valid != '1) begin
         errors++;
         $display("FAIL R10: queues full ready actual=%b expected=0 valid=%h", in_ready, task_valid);
      end
      repeat (5) begin
         @(negedge clk);
         service();
         in_valid = 1'b1;
         in_data  = all_a;
         checks++;
         if (in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R10: stalled ready actual=%b expected=0", in_ready);
         end
      end
      ready_pct = 100;
      offer(all_a);
      idle(QDEPTH + 8);
      count_check("R10");

      // spread (R11)
      tag = "R11";
      seen_units = '0;
      for (int b = 0; b < 32; b++) offer(lead_a);
      idle(QDEPTH + 8);
      count_check("R11");
      checks++;
      if ($countones(seen_units) < 4) begin
         errors++;
         $display("FAIL R11: units used actual=%0d expected>=4", $countones(seen_units));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule